// File: doc/BRIEF.md
# Multi-Pool Free Buffer Pointer Manager

This block keeps four rings of free buffer pointers in on-chip storage, one ring per pool. Software hands a buffer back by writing its address into a per-pool slot of an access window. It takes a buffer by reading that same slot, which yields the oldest pointer still held in the ring. Each pool has its own small register group: a ring base word carrying an enable flag, programmed read and write indices, and a size word that also holds the pool's role and the ports allowed to use it. A global command register runs, pauses or stops the manager, and a status word reports the state together with sticky per-pool error flags.

A receive-side requester gives a port number and a packet length. The block answers with a pointer from that port's short pool when the packet is small and such a pool is assigned. Otherwise the answer comes from the port's long pool. Every request, on the bus or on the receive side, is served in one clock cycle. Read data and receive answers appear exactly one cycle after the request.

Top module: `buf_ptr_mgr`

## Requirements
- R1: After reset the manager is stopped, the status word at offset 0x0 reads 0, every pool size field reads 128, and every index register reads 0.
- R2: The register group of pool p sits at byte offset 0x10+16*p and holds four words. +0x0 is the ring base, with the pool enable in bit 0, and reads back exactly as written. +0x4 holds the read index and +0x8 the write index. +0xC holds the size in bits 13:0, the role in bits 17:16 (0 unused, 1 long, 2 short) and the port bitmap in bits 27:24.
- R3: An index register takes the programmed index from bits 15:2 of a write. On read it returns the programmed index in bits 15:2 and the live ring index in bits 31:18.
- R4: A size write is accepted only when the size is a multiple of 32, at least 128 and at most the smaller of 16352 and the ring depth. Any other size write leaves the whole size word unchanged.
- R5: A write to offset 0x4 is a command: bit 1 stops, bit 2 pauses and bit 0 starts, with stop taking priority over pause and pause over start. Status bits 5:4 read 00 when stopped, 01 when running and 10 when paused. Pause acts only while running.
- R6: Access-window address bits 9:8 select the pool. A window write pushes a pointer and a window read pops the oldest one, with the data and bus_rvalid one cycle after the request. Ring indices wrap from size-1 to 0.
- R7: While running, a pop from an empty or disabled pool returns 0 and sets sticky empty flag bit 8+p of the status word. Writing 1 to a flag bit at offset 0x0 clears it.
- R8: While running, a push into a full or disabled pool is dropped and sets sticky overflow flag bit 12+p. A push whose bits 4:0 are not zero is dropped without setting a flag.
- R9: While stopped or paused, window reads return 0 and set no flag, and window writes are dropped.
- R10: Stop empties every ring. Start from stopped reloads each live index from its programmed value, with occupancy (write - read) modulo size. Start from paused resumes with the ring contents intact.
- R11: A receive request is answered one cycle later on rx_valid with a pointer, a pool index and a short flag. The short pool is used when the length is at most 256 and an enabled short pool lists the port. Otherwise the enabled long pool listing the port is used. The lowest pool index wins among candidates.
- R12: When no pool is eligible, or the chosen pool is empty, rx_ptr is 0, and an empty chosen pool sets its empty flag. rx_ready is low in any cycle with a bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_win | input | 1 | 1 = access window, 0 = register space |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 32 | Read data |
| rx_req | input | 1 | Receive-side pointer request |
| rx_ready | output | 1 | Receive request accepted this cycle |
| rx_port | input | 2 | Requesting port |
| rx_len | input | LENW | Packet length in bytes |
| rx_valid | output | 1 | Receive answer valid |
| rx_ptr | output | 32 | Granted pointer, 0 on failure |
| rx_pool | output | 2 | Pool the answer came from |
| rx_short | output | 1 | Answer came from a short pool |

## Verification
The size field is swept in steps of 8 from 0 to 320, which separates accepted sizes from ones rejected as unaligned, too small or too deep. Interleaved pushes across all four pools, followed by pops per pool, distinguish correct pool decoding and first-in first-out order from crossed pools or reversed order. A full fill to capacity, a ring started near its top index, and pushes to disabled, paused or stopped pools probe the wrap, overflow and ignore paths. Receive requests at lengths 64, 256 and 257 from ports with and without a short pool expose errors in the length threshold and in the port filtering.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
    localparam int NPOOL = 4;
    localparam int PW    = 2;
    localparam int IW    = 14;
    localparam int CW    = IW + 1;

    typedef enum logic [1:0] {
        PT_FREE  = 2'd0,
        PT_LONG  = 2'd1,
        PT_SHORT = 2'd2
    } ptype_e;

    typedef enum logic [1:0] {
        MS_STOP  = 2'b00,
        MS_RUN   = 2'b01,
        MS_PAUSE = 2'b10
    } mstate_e;

    typedef struct packed {
        logic [31:0]      base;
        logic [IW-1:0]    prog_rd;
        logic [IW-1:0]    prog_wr;
        logic [IW-1:0]    live_rd;
        logic [IW-1:0]    live_wr;
        logic [CW-1:0]    count;
        logic [IW-1:0]    size;
        logic [1:0]       typ;
        logic [NPOOL-1:0] pmap;
    } pool_t;
endpackage

// File: rtl/bpm_ring_ram.sv
module bpm_ring_ram #(
    parameter int DW = 32,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int ENTRIES = 2 ** AW;

    logic [DW-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/bpm_pool_sel.sv
module bpm_pool_sel
    import bpm_pkg::*;
#(
    parameter int LENW      = 14,
    parameter int SHORT_MAX = 256
) (
    input  logic [NPOOL-1:0] en,
    input  logic [1:0]       typ  [NPOOL],
    input  logic [NPOOL-1:0] pmap [NPOOL],
    input  logic [PW-1:0]    port,
    input  logic [LENW-1:0]  len,
    output logic             found,
    output logic [PW-1:0]    idx,
    output logic             is_short
);
    logic [NPOOL-1:0] short_m;
    logic [NPOOL-1:0] long_m;

    for (genvar g = 0; g < NPOOL; g++) begin : g_match
        assign short_m[g] = en[g] && (typ[g] == PT_SHORT) && pmap[g][port];
        assign long_m[g]  = en[g] && (typ[g] == PT_LONG)  && pmap[g][port];
    end

    logic          s_f, l_f, use_s;
    logic [PW-1:0] s_i, l_i;

    always_comb begin
        s_f = 1'b0; s_i = '0;
        l_f = 1'b0; l_i = '0;
        for (int i = NPOOL - 1; i >= 0; i--) begin
            if (short_m[i]) begin s_f = 1'b1; s_i = PW'(i); end
            if (long_m[i])  begin l_f = 1'b1; l_i = PW'(i); end
        end
        use_s    = s_f && (int'(len) <= SHORT_MAX);
        found    = use_s || l_f;
        idx      = use_s ? s_i : l_i;
        is_short = use_s;
    end
endmodule

// File: rtl/buf_ptr_mgr.sv
module buf_ptr_mgr
    import bpm_pkg::*;
#(
    parameter int DEPTH     = 256,
    parameter int ADDR_W    = 12,
    parameter int LENW      = 14,
    parameter int SHORT_MAX = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_win,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_rvalid,
    output logic [31:0]       bus_rdata,
    input  logic              rx_req,
    output logic              rx_ready,
    input  logic [PW-1:0]     rx_port,
    input  logic [LENW-1:0]   rx_len,
    output logic              rx_valid,
    output logic [31:0]       rx_ptr,
    output logic [PW-1:0]     rx_pool,
    output logic              rx_short
);
    localparam int RAW    = $clog2(DEPTH);
    localparam int AW     = PW + RAW;
    localparam int MAXCAP = (DEPTH < 16352) ? DEPTH : 16352;
    localparam int MINCAP = 128;

    typedef struct packed {
        mstate_e                 state;
        logic [NPOOL-1:0]        emp;
        logic [NPOOL-1:0]        ovf;
        pool_t [NPOOL-1:0]       pc;
        logic                    rvalid;
        logic                    rsrc;
        logic [31:0]             rdata;
        logic                    rxv;
        logic                    rxok;
        logic [PW-1:0]           rxpool;
        logic                    rxshort;
    } st_t;

    st_t q, d;

    function automatic st_t reset_val();
        st_t r;
        r = '0;
        r.state = MS_STOP;
        for (int i = 0; i < NPOOL; i++) r.pc[i].size = IW'(MINCAP);
        return r;
    endfunction

    function automatic logic [IW-1:0] nxt(input logic [IW-1:0] idx, input logic [IW-1:0] sz);
        return ((CW'(idx) + CW'(1)) >= CW'(sz)) ? '0 : idx + IW'(1);
    endfunction

    function automatic logic [CW-1:0] occ(input logic [IW-1:0] wr, input logic [IW-1:0] rd,
                                          input logic [IW-1:0] sz);
        return (wr >= rd) ? CW'(wr - rd) : CW'(wr) + CW'(sz) - CW'(rd);
    endfunction

    // ring storage
    logic          ram_we, ram_re;
    logic [AW-1:0] ram_waddr, ram_raddr;
    logic [31:0]   ram_wdata, ram_rdata;

    bpm_ring_ram #(.DW(32), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .re    (ram_re),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    // receive-side pool choice
    logic [NPOOL-1:0] p_en;
    logic [1:0]       p_typ [NPOOL];
    logic [NPOOL-1:0] p_map [NPOOL];
    logic             sel_found, sel_short;
    logic [PW-1:0]    sel_idx;

    for (genvar g = 0; g < NPOOL; g++) begin : g_cfg
        assign p_en[g]  = q.pc[g].base[0];
        assign p_typ[g] = q.pc[g].typ;
        assign p_map[g] = q.pc[g].pmap;
    end

    bpm_pool_sel #(.LENW(LENW), .SHORT_MAX(SHORT_MAX)) u_sel (
        .en       (p_en),
        .typ      (p_typ),
        .pmap     (p_map),
        .port     (rx_port),
        .len      (rx_len),
        .found    (sel_found),
        .idx      (sel_idx),
        .is_short (sel_short)
    );

    logic          run;
    logic [PW-1:0] wp, rp;
    logic [2:0]    grp;
    logic [1:0]    sub;
    logic          grp_hit;
    logic [IW-1:0] new_sz;
    logic          sz_ok;

    assign rx_ready = !bus_valid;

    always_comb begin
        d = q;
        d.rvalid = 1'b0; d.rsrc = 1'b0; d.rdata = '0;
        d.rxv = 1'b0; d.rxok = 1'b0; d.rxshort = 1'b0;
        ram_we = 1'b0; ram_waddr = '0; ram_wdata = '0;
        ram_re = 1'b0; ram_raddr = '0;

        run     = (q.state == MS_RUN);
        wp      = bus_addr[9:8];
        grp     = bus_addr[6:4];
        sub     = bus_addr[3:2];
        rp      = PW'(grp - 3'd1);
        grp_hit = (bus_addr[ADDR_W-1:7] == '0) && (grp >= 3'd1) && (grp <= 3'd4)
                  && (bus_addr[1:0] == 2'b00);
        new_sz  = bus_wdata[IW-1:0];
        sz_ok   = (new_sz[4:0] == 5'd0) && (int'(new_sz) >= MINCAP) && (int'(new_sz) <= MAXCAP);

        if (bus_valid && bus_win) begin
            if (bus_write) begin
                if (run && bus_wdata[4:0] == 5'd0) begin
                    if (!q.pc[wp].base[0] || q.pc[wp].count == CW'(q.pc[wp].size)) begin
                        d.ovf[wp] = 1'b1;
                    end else begin
                        ram_we    = 1'b1;
                        ram_waddr = {wp, q.pc[wp].live_wr[RAW-1:0]};
                        ram_wdata = bus_wdata;
                        d.pc[wp].live_wr = nxt(q.pc[wp].live_wr, q.pc[wp].size);
                        d.pc[wp].count   = q.pc[wp].count + CW'(1);
                    end
                end
            end else begin
                d.rvalid = 1'b1;
                if (run) begin
                    if (q.pc[wp].base[0] && q.pc[wp].count != '0) begin
                        d.rsrc    = 1'b1;
                        ram_re    = 1'b1;
                        ram_raddr = {wp, q.pc[wp].live_rd[RAW-1:0]};
                        d.pc[wp].live_rd = nxt(q.pc[wp].live_rd, q.pc[wp].size);
                        d.pc[wp].count   = q.pc[wp].count - CW'(1);
                    end else begin
                        d.emp[wp] = 1'b1;
                    end
                end
            end
        end else if (bus_valid) begin
            if (bus_write) begin
                if (bus_addr == ADDR_W'(0)) begin
                    d.emp = q.emp & ~bus_wdata[11:8];
                    d.ovf = q.ovf & ~bus_wdata[15:12];
                end else if (bus_addr == ADDR_W'(4)) begin
                    if (bus_wdata[1]) begin
                        d.state = MS_STOP;
                        for (int i = 0; i < NPOOL; i++) begin
                            d.pc[i].count   = '0;
                            d.pc[i].live_rd = q.pc[i].prog_rd;
                            d.pc[i].live_wr = q.pc[i].prog_wr;
                        end
                    end else if (bus_wdata[2]) begin
                        if (run) d.state = MS_PAUSE;
                    end else if (bus_wdata[0]) begin
                        d.state = MS_RUN;
                        if (q.state == MS_STOP) begin
                            for (int i = 0; i < NPOOL; i++) begin
                                d.pc[i].live_rd = q.pc[i].prog_rd;
                                d.pc[i].live_wr = q.pc[i].prog_wr;
                                d.pc[i].count   = occ(q.pc[i].prog_wr, q.pc[i].prog_rd, q.pc[i].size);
                            end
                        end
                    end
                end else if (grp_hit) begin
                    case (sub)
                        2'd0: d.pc[rp].base    = bus_wdata;
                        2'd1: d.pc[rp].prog_rd = bus_wdata[15:2];
                        2'd2: d.pc[rp].prog_wr = bus_wdata[15:2];
                        default: begin
                            if (sz_ok) begin
                                d.pc[rp].size = new_sz;
                                d.pc[rp].typ  = bus_wdata[17:16];
                                d.pc[rp].pmap = bus_wdata[27:24];
                            end
                        end
                    endcase
                end
            end else begin
                d.rvalid = 1'b1;
                if (bus_addr == ADDR_W'(0)) begin
                    d.rdata = {16'd0, q.ovf, q.emp, 2'b00, q.state, 4'd0};
                end else if (grp_hit) begin
                    case (sub)
                        2'd0: d.rdata = q.pc[rp].base;
                        2'd1: d.rdata = {q.pc[rp].live_rd, 2'b00, q.pc[rp].prog_rd, 2'b00};
                        2'd2: d.rdata = {q.pc[rp].live_wr, 2'b00, q.pc[rp].prog_wr, 2'b00};
                        default: d.rdata = {4'd0, q.pc[rp].pmap, 6'd0, q.pc[rp].typ, 2'b00, q.pc[rp].size};
                    endcase
                end
            end
        end

        if (rx_req && !bus_valid) begin
            d.rxv     = 1'b1;
            d.rxpool  = sel_idx;
            d.rxshort = sel_found && sel_short;
            if (run && sel_found) begin
                if (q.pc[sel_idx].count != '0) begin
                    d.rxok    = 1'b1;
                    ram_re    = 1'b1;
                    ram_raddr = {sel_idx, q.pc[sel_idx].live_rd[RAW-1:0]};
                    d.pc[sel_idx].live_rd = nxt(q.pc[sel_idx].live_rd, q.pc[sel_idx].size);
                    d.pc[sel_idx].count   = q.pc[sel_idx].count - CW'(1);
                end else begin
                    d.emp[sel_idx] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= reset_val();
        else        q <= d;
    end

    assign bus_rvalid = q.rvalid;
    assign bus_rdata  = q.rsrc ? ram_rdata : q.rdata;
    assign rx_valid   = q.rxv;
    assign rx_ptr     = q.rxok ? ram_rdata : 32'd0;
    assign rx_pool    = q.rxpool;
    assign rx_short   = q.rxshort;
endmodule

// File: rtl/bpm_sva.sv
module bpm_sva #(
    parameter int LENW      = 14,
    parameter int SHORT_MAX = 256
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_valid,
    input logic            bus_write,
    input logic            bus_win,
    input logic            bus_rvalid,
    input logic [31:0]     bus_rdata,
    input logic            rx_req,
    input logic            rx_ready,
    input logic [LENW-1:0] rx_len,
    input logic            rx_valid,
    input logic [31:0]     rx_ptr,
    input logic            rx_short
);
    a_r6_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_write |=> bus_rvalid);

    a_r6_no_stray_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_valid && !bus_write));

    a_r8_pop_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid && $past(bus_win) |-> bus_rdata[4:0] == 5'd0);

    a_r11_rx_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rx_req && rx_ready |=> rx_valid);

    a_r11_short_len: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_short |-> int'($past(rx_len)) <= SHORT_MAX);

    a_r12_rx_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> rx_ptr[4:0] == 5'd0);
endmodule

bind buf_ptr_mgr bpm_sva #(.LENW(LENW), .SHORT_MAX(SHORT_MAX)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_win    (bus_win),
    .bus_rvalid (bus_rvalid),
    .bus_rdata  (bus_rdata),
    .rx_req     (rx_req),
    .rx_ready   (rx_ready),
    .rx_len     (rx_len),
    .rx_valid   (rx_valid),
    .rx_ptr     (rx_ptr),
    .rx_short   (rx_short)
);

// File: tb/buf_ptr_mgr_tb.sv
`timescale 1ns/1ps
module buf_ptr_mgr_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0, bus_win = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;
    logic        rx_req = 1'b0;
    logic        rx_ready;
    logic [1:0]  rx_port = '0;
    logic [13:0] rx_len = '0;
    logic        rx_valid;
    logic [31:0] rx_ptr;
    logic [1:0]  rx_pool;
    logic        rx_short;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    buf_ptr_mgr u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_win(bus_win),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .rx_req(rx_req), .rx_ready(rx_ready), .rx_port(rx_port), .rx_len(rx_len),
        .rx_valid(rx_valid), .rx_ptr(rx_ptr), .rx_pool(rx_pool), .rx_short(rx_short)
    );

    function automatic logic [11:0] pa(input int p, input int s);
        return 12'(16 + 16 * p + 4 * s);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic win, input logic [11:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_win = win; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic win, input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_win = win; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        v = bus_rvalid ? bus_rdata : 32'hDEAD_BEEF;
    endtask

    task automatic push(input int p, input logic [31:0] v);
        wr(1'b1, 12'(p << 8), v);
    endtask

    task automatic pop_chk(input string tag, input int p, input logic [31:0] exp);
        logic [31:0] v;
        rd(1'b1, 12'(p << 8), v);
        chk(tag, v, exp);
    endtask

    task automatic reg_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(1'b0, a, v);
        chk(tag, v, exp);
    endtask

    task automatic rx_chk(input string tag, input logic [1:0] port, input int len,
                          input logic [31:0] eptr, input logic [1:0] epool, input logic eshort);
        @(negedge clk);
        rx_req = 1'b1; rx_port = port; rx_len = 14'(len);
        @(negedge clk);
        rx_req = 1'b0;
        chk({tag, " valid"}, 32'(rx_valid), 32'd1);
        chk({tag, " ptr"}, rx_ptr, eptr);
        if (eptr != 0) begin
            chk({tag, " pool"}, 32'(rx_pool), 32'(epool));
            chk({tag, " short"}, 32'(rx_short), 32'(eshort));
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int prev;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_chk("R1 status", 12'h000, 32'h0);
        for (int p = 0; p < 4; p++) reg_chk("R1 size", pa(p, 3), 32'd128);
        reg_chk("R1 rd idx", pa(0, 1), 32'h0);
        reg_chk("R1 wr idx", pa(2, 2), 32'h0);

        // R2 base words read back per pool
        for (int p = 0; p < 4; p++) begin
            wr(1'b0, pa(p, 0), 32'hA5A5_0000 | 32'(p << 12) | 32'h1);
            reg_chk("R2 base", pa(p, 0), 32'hA5A5_0000 | 32'(p << 12) | 32'h1);
        end

        // R4 size legality sweep
        prev = 128;
        for (int s = 0; s <= 320; s += 8) begin
            wr(1'b0, pa(0, 3), 32'(s));
            if ((s % 32 == 0) && s >= 128 && s <= 256) prev = s;
            reg_chk("R4 size sweep", pa(0, 3), 32'(prev));
        end

        // R2 role / port map setup
        wr(1'b0, pa(0, 3), (32'h1 << 24) | (32'd1 << 16) | 32'd128);
        wr(1'b0, pa(1, 3), (32'h2 << 24) | (32'd1 << 16) | 32'd128);
        wr(1'b0, pa(2, 3), (32'h5 << 24) | (32'd2 << 16) | 32'd128);
        wr(1'b0, pa(3, 3), 32'd128);
        reg_chk("R2 size word", pa(2, 3), 32'h0502_0080);

        // R3 index programming
        wr(1'b0, pa(3, 1), 32'h0000_01FF);
        reg_chk("R3 rd idx", pa(3, 1), 32'h0000_01FC);
        wr(1'b0, pa(3, 1), 32'h0);

        // R5 commands
        wr(1'b0, 12'h004, 32'h1); reg_chk("R5 run", 12'h000, 32'h10);
        wr(1'b0, 12'h004, 32'h4); reg_chk("R5 pause", 12'h000, 32'h20);
        wr(1'b0, 12'h004, 32'h1); reg_chk("R5 resume", 12'h000, 32'h10);
        wr(1'b0, 12'h004, 32'h7); reg_chk("R5 stop prio", 12'h000, 32'h0);
        wr(1'b0, 12'h004, 32'h5); reg_chk("R5 pause prio", 12'h000, 32'h0);

        // R9 stopped: window ignored
        push(0, 32'h40);
        pop_chk("R9 stopped pop", 0, 32'h0);
        reg_chk("R9 no flag", 12'h000, 32'h0);
        wr(1'b0, 12'h004, 32'h1);
        pop_chk("R7 empty pop", 0, 32'h0);
        reg_chk("R7 empty flag", 12'h000, 32'h110);
        wr(1'b0, 12'h000, 32'h100);
        reg_chk("R7 w1c", 12'h000, 32'h10);

        // R6 interleaved pushes, FIFO pops per pool
        for (int k = 0; k < 6; k++)
            for (int p = 0; p < 4; p++) push(p, 32'((p + 1) << 16) | 32'(k << 5));
        for (int p = 0; p < 4; p++)
            for (int k = 0; k < 6; k++) pop_chk("R6 fifo", p, 32'((p + 1) << 16) | 32'(k << 5));

        // R8 fill to capacity then overflow
        for (int k = 0; k < 128; k++) push(3, 32'h0030_0000 | 32'(k << 5));
        push(3, 32'h00FF_0000);
        reg_chk("R8 ovf flag", 12'h000, 32'h8010);
        for (int k = 0; k < 128; k++) pop_chk("R8 full drain", 3, 32'h0030_0000 | 32'(k << 5));
        wr(1'b0, 12'h000, 32'hFF00);

        // R8 unaligned push dropped without flag
        push(2, 32'h1001);
        pop_chk("R8 unaligned", 2, 32'h0);
        reg_chk("R8 unaligned flags", 12'h000, 32'h0410);
        wr(1'b0, 12'h000, 32'hFF00);

        // R7/R8 disabled pool
        wr(1'b0, pa(1, 0), 32'hA5A5_1000);
        push(1, 32'h500);
        reg_chk("R8 disabled push", 12'h000, 32'h2010);
        pop_chk("R7 disabled pop", 1, 32'h0);
        reg_chk("R7 disabled flag", 12'h000, 32'h2210);
        wr(1'b0, 12'h000, 32'hFF00);
        wr(1'b0, pa(1, 0), 32'hA5A5_1001);

        // R9/R10 pause keeps contents
        push(0, 32'h100); push(0, 32'h120);
        wr(1'b0, 12'h004, 32'h4);
        pop_chk("R9 paused pop", 0, 32'h0);
        push(0, 32'h140);
        reg_chk("R9 paused flags", 12'h000, 32'h20);
        wr(1'b0, 12'h004, 32'h1);
        pop_chk("R10 resume A", 0, 32'h100);
        pop_chk("R10 resume B", 0, 32'h120);
        pop_chk("R9 paused push dropped", 0, 32'h0);
        wr(1'b0, 12'h000, 32'hFF00);

        // R10 stop empties, start re-arms
        push(0, 32'h200);
        wr(1'b0, 12'h004, 32'h2);
        wr(1'b0, 12'h004, 32'h1);
        pop_chk("R10 stop clears", 0, 32'h0);
        wr(1'b0, 12'h000, 32'hFF00);
        push(0, 32'h300); push(0, 32'h320);
        pop_chk("R10 pre A", 0, 32'h300);
        pop_chk("R10 pre B", 0, 32'h320);
        wr(1'b0, 12'h004, 32'h2);
        wr(1'b0, pa(0, 2), 32'h8);
        wr(1'b0, 12'h004, 32'h1);
        reg_chk("R10 wr idx live", pa(0, 2), (32'd2 << 18) | 32'h8);
        pop_chk("R10 rearm A", 0, 32'h300);
        pop_chk("R10 rearm B", 0, 32'h320);
        pop_chk("R10 rearm empty", 0, 32'h0);
        wr(1'b0, 12'h000, 32'hFF00);
        wr(1'b0, 12'h004, 32'h2);
        wr(1'b0, pa(0, 2), 32'h0);

        // R6/R3 wrap at size
        wr(1'b0, pa(3, 1), 32'(126 << 2));
        wr(1'b0, pa(3, 2), 32'(126 << 2));
        wr(1'b0, 12'h004, 32'h1);
        reg_chk("R3 live rd", pa(3, 1), (32'd126 << 18) | 32'(126 << 2));
        for (int k = 0; k < 4; k++) push(3, 32'h0077_0000 | 32'(k << 5));
        for (int k = 0; k < 4; k++) pop_chk("R6 wrap", 3, 32'h0077_0000 | 32'(k << 5));
        reg_chk("R6 wrap idx", pa(3, 1), (32'd2 << 18) | 32'(126 << 2));
        wr(1'b0, 12'h004, 32'h2);
        wr(1'b0, pa(3, 1), 32'h0);
        wr(1'b0, pa(3, 2), 32'h0);
        wr(1'b0, 12'h004, 32'h1);

        // R11 receive-side pool choice
        push(0, 32'h1000); push(1, 32'h2000);
        push(2, 32'h3000); push(2, 32'h3020);
        rx_chk("R11 p0 len64 short", 2'd0, 64, 32'h3000, 2'd2, 1'b1);
        rx_chk("R11 p0 len257 long", 2'd0, 257, 32'h1000, 2'd0, 1'b0);
        rx_chk("R11 p2 len256 short", 2'd2, 256, 32'h3020, 2'd2, 1'b1);
        rx_chk("R11 p1 no short", 2'd1, 64, 32'h2000, 2'd1, 1'b0);
        rx_chk("R12 no pool", 2'd3, 64, 32'h0, 2'd0, 1'b0);
        reg_chk("R12 no pool no flag", 12'h000, 32'h10);
        rx_chk("R12 empty long", 2'd0, 500, 32'h0, 2'd0, 1'b0);
        reg_chk("R12 empty flag", 12'h000, 32'h110);

        // R12 ready blocked by bus activity
        @(negedge clk);
        chk("R12 ready idle", 32'(rx_ready), 32'd1);
        bus_valid = 1'b1; bus_write = 1'b0; bus_win = 1'b0; bus_addr = 12'h000;
        #1;
        chk("R12 ready busy", 32'(rx_ready), 32'd0);
        @(negedge clk);
        bus_valid = 1'b0;

        done = 1'b1;
        summary();
        $finish;
    end
endmodule